// File: doc/BRIEF.md
# Exclusive Access Monitor

This block sits in front of a shared memory target and makes load-linked / store-conditional updates work when several bus masters share that target. Every request arrives on one channel: the requester's ID, a byte address, a read or write direction, an exclusive flag and a two-bit cache attribute. An exclusive read places a reservation for the requesting master on the aligned 8-byte granule that holds the address. A later exclusive write from that master is committed to memory only if the reservation is still in place. Otherwise the write is dropped and the master receives an ordinary OKAY instead of EXOKAY, so its software knows to retry.

Each master holds at most one reservation. A reservation is lost when another master makes a committed write to the same granule, when the holder's own exclusive write commits, when the clear input is pulsed (for example from an interrupt handler's clear-exclusive path), or, in hold mode, when it ages out. The `holdMode` input chooses the hand-off policy. With `holdMode` low (steal), a later exclusive read takes the granule from the current holder. With `holdMode` high (hold), that read is refused while the holder's reservation is live, and a timeout makes sure a stalled holder cannot block everyone else indefinitely.

Every request is answered exactly one cycle later. In that same cycle `memWrEn` tells the memory whether the write may be performed.

Top module: `excl_monitor`

## Requirements
- R1: A request with `reqValid` high at a clock edge produces `rspValid` high in the following cycle, with `rspId` equal to the request's ID. No response is produced in a cycle that follows an edge without a request.
- R2: A non-exclusive access always returns code 0 (OKAY). A non-exclusive write raises `memWrEn` with its response, and a read of either kind never raises it.
- R3: An exclusive read with attribute 0 that is granted returns code 1 (EXOKAY). A following exclusive write from the same master commits (code 1, `memWrEn` high) when the two addresses agree in every bit above bit 2, that is, they fall in the same 8-byte granule.
- R4: An exclusive write from a master with no matching reservation fails: code 0 and `memWrEn` low. The failure leaves every reservation as it was, so a reservation holder that was not the writer can still commit.
- R5: A committed write from a different master (plain, or exclusive and successful) to the reserved granule cancels the reservation. Writes to other granules, and the holder's own plain writes, do not cancel it.
- R6: A committed exclusive write also drops the writer's own reservation. A second exclusive write without a fresh exclusive read fails.
- R7: With `holdMode` low, an exclusive read from a second master to a reserved granule is granted (code 1) and moves the reservation to that master. The first master's exclusive write then fails and the second master's commits. Reservations never expire in this mode.
- R8: With `holdMode` high, an exclusive read from a second master to a granule reserved by another master is refused (code 0) and does not get a reservation. The first master's exclusive write still commits.
- R9: With `holdMode` high, a reservation granted at clock edge E is honoured by an exclusive write sampled at edge E+d for 1 <= d <= TIMEOUT_CYCLES and is gone for larger d. After it expires, another master's exclusive read is granted.
- R10: `clrResv` high at an edge drops every reservation. An exclusive read sampled at that same edge is not granted (code 0), and an exclusive write that follows a clear fails.
- R11: An exclusive access with a nonzero cache attribute (bit 0 bufferable, bit 1 cacheable) is not monitored. A read of this kind gets code 0 and creates no reservation. A write of this kind fails with `memWrEn` low and leaves the reservations untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| holdMode | input | 1 | 1: hold policy with timeout, 0: steal policy |
| clrResv | input | 1 | Drop all reservations |
| reqValid | input | 1 | Request present this cycle |
| reqId | input | ID_W | Requesting master |
| reqAddr | input | ADDR_W | Byte address |
| reqWrite | input | 1 | 1 write, 0 read |
| reqExcl | input | 1 | Exclusive access |
| reqCache | input | 2 | Bit 0 bufferable, bit 1 cacheable |
| rspValid | output | 1 | Response present |
| rspId | output | ID_W | Master the response belongs to |
| rspCode | output | 2 | 0 OKAY, 1 EXOKAY |
| memWrEn | output | 1 | Write may be committed to memory |

## Verification
The assertions check, on every cycle, the properties that can be read directly from the pins: the one-cycle response timing and its ID, that plain accesses get OKAY, that `memWrEn` follows the exclusive outcome, that dirty-attribute exclusives are rejected, and that a write placed right after a clear fails. Ownership itself lives in internal state and builds up over many requests: steal versus hold hand-off, cancellation by a neighbour's write, a failed write leaving the monitor where it was, and the exact cycle at which a reservation ages out. Only the bench's request sequences can show those, including the sweeps over granule offsets and timeout distances.

// File: rtl/exmon_pkg.sv
package exmon_pkg;

  typedef enum logic [1:0] {
    RSP_OKAY   = 2'd0,
    RSP_EXOKAY = 2'd1
  } rsp_code_e;

  // strobes from control to the reservation table
  typedef struct packed {
    logic reserve;     // install reservation for the requester
    logic wipeOthers;  // drop other masters' entries on the request granule
    logic wipeOwn;     // drop requester's entry if it matches the granule
    logic wipeAll;     // drop everything
  } resv_cmd_t;

endpackage

// File: rtl/exmon_resv_table.sv
module exmon_resv_table
  import exmon_pkg::*;
#(
  parameter int NUM_MASTERS    = 4,
  parameter int ID_W           = 2,
  parameter int TAG_W          = 29,
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             holdMode,
  input  resv_cmd_t        cmd,
  input  logic [ID_W-1:0]  reqId,
  input  logic [TAG_W-1:0] reqTag,
  output logic             ownHit,
  output logic             otherHit
);

  localparam int AGE_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(TIMEOUT_CYCLES - 1);

  logic [NUM_MASTERS-1:0] entHit;
  logic [NUM_MASTERS-1:0] isMe;

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_ent
    logic             entValid;
    logic [TAG_W-1:0] entTag;
    logic [AGE_W-1:0] entAge;

    assign isMe[m]   = (reqId == ID_W'(m));
    assign entHit[m] = entValid && (entTag == reqTag);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        entValid <= 1'b0;
        entTag   <= '0;
        entAge   <= '0;
      end else if (cmd.wipeAll) begin
        entValid <= 1'b0;
      end else if (cmd.reserve && isMe[m]) begin
        entValid <= 1'b1;
        entTag   <= reqTag;
        entAge   <= '0;
      end else if (entHit[m] && ((cmd.wipeOthers && !isMe[m]) ||
                                 (cmd.wipeOwn && isMe[m]))) begin
        entValid <= 1'b0;
      end else if (entValid && holdMode) begin
        if (entAge == AGE_LAST) entValid <= 1'b0;
        else                    entAge   <= entAge + 1'b1;
      end
    end
  end

  assign ownHit   = |(entHit & isMe);
  assign otherHit = |(entHit & ~isMe);

endmodule

// File: rtl/exmon_ctrl.sv
module exmon_ctrl
  import exmon_pkg::*;
#(
  parameter int ID_W = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            holdMode,
  input  logic            clrResv,
  input  logic            reqValid,
  input  logic [ID_W-1:0] reqId,
  input  logic            reqWrite,
  input  logic            reqExcl,
  input  logic [1:0]      reqCache,
  input  logic            ownHit,
  input  logic            otherHit,
  output resv_cmd_t       cmd,
  output logic            rspValid,
  output logic [ID_W-1:0] rspId,
  output logic [1:0]      rspCode,
  output logic            memWrEn
);

  logic attrClean;
  logic exOk;
  logic wrCommit;

  assign attrClean = (reqCache == 2'b00);

  always_comb begin
    cmd      = '0;
    exOk     = 1'b0;
    wrCommit = 1'b0;
    if (reqValid) begin
      unique case ({reqWrite, reqExcl})
        2'b01: begin  // exclusive read
          exOk           = attrClean && !clrResv && (!holdMode || !otherHit);
          cmd.reserve    = exOk;
          cmd.wipeOthers = exOk && !holdMode;
        end
        2'b11: begin  // exclusive write
          exOk           = attrClean && ownHit;
          wrCommit       = exOk;
          cmd.wipeOthers = exOk;
          cmd.wipeOwn    = exOk;
        end
        2'b10: begin  // plain write
          wrCommit       = 1'b1;
          cmd.wipeOthers = 1'b1;
        end
        default: ;    // plain read
      endcase
    end
    cmd.wipeAll = clrResv;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspId    <= '0;
      rspCode  <= RSP_OKAY;
      memWrEn  <= 1'b0;
    end else begin
      rspValid <= reqValid;
      rspId    <= reqId;
      rspCode  <= exOk ? RSP_EXOKAY : RSP_OKAY;
      memWrEn  <= wrCommit;
    end
  end

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import exmon_pkg::*;
#(
  parameter int NUM_MASTERS    = 4,
  parameter int ADDR_W         = 32,
  parameter int GRANULE_LG2    = 3,
  parameter int TIMEOUT_CYCLES = 64,
  parameter int ID_W           = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              holdMode,
  input  logic              clrResv,
  input  logic              reqValid,
  input  logic [ID_W-1:0]   reqId,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqExcl,
  input  logic [1:0]        reqCache,
  output logic              rspValid,
  output logic [ID_W-1:0]   rspId,
  output logic [1:0]        rspCode,
  output logic              memWrEn
);

  localparam int TAG_W = ADDR_W - GRANULE_LG2;

  resv_cmd_t cmd;
  logic      ownHit;
  logic      otherHit;

  exmon_ctrl #(.ID_W(ID_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .holdMode(holdMode), .clrResv(clrResv),
    .reqValid(reqValid), .reqId(reqId), .reqWrite(reqWrite),
    .reqExcl(reqExcl), .reqCache(reqCache),
    .ownHit(ownHit), .otherHit(otherHit), .cmd(cmd),
    .rspValid(rspValid), .rspId(rspId), .rspCode(rspCode), .memWrEn(memWrEn)
  );

  exmon_resv_table #(
    .NUM_MASTERS(NUM_MASTERS), .ID_W(ID_W), .TAG_W(TAG_W),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) u_table (
    .clk(clk), .rstN(rstN), .holdMode(holdMode), .cmd(cmd),
    .reqId(reqId), .reqTag(reqAddr[ADDR_W-1:GRANULE_LG2]),
    .ownHit(ownHit), .otherHit(otherHit)
  );

endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk #(
  parameter int ID_W   = 2,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              clrResv,
  input logic              reqValid,
  input logic [ID_W-1:0]   reqId,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqWrite,
  input logic              reqExcl,
  input logic [1:0]        reqCache,
  input logic              rspValid,
  input logic [ID_W-1:0]   rspId,
  input logic [1:0]        rspCode,
  input logic              memWrEn
);

  a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (rspValid && rspId == $past(reqId)));

  a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  a_r2_plain_okay: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqExcl) |=> (rspCode == 2'd0));

  a_r2_plain_write_commits: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && !reqExcl) |=> memWrEn);

  a_r2_read_no_commit: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite) |=> !memWrEn);

  a_r4_commit_matches_code: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqExcl) |=> (memWrEn == (rspCode == 2'd1)));

  a_r11_dirty_attr_fails: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqExcl && reqCache != 2'b00) |=> (rspCode == 2'd0 && !memWrEn));

  a_r10_write_after_clear_fails: assert property (@(posedge clk) disable iff (!rstN)
    clrResv ##1 (reqValid && reqWrite && reqExcl) |=> (rspCode == 2'd0));

endmodule

bind excl_monitor excl_monitor_chk #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .clrResv(clrResv), .reqValid(reqValid),
  .reqId(reqId), .reqAddr(reqAddr), .reqWrite(reqWrite), .reqExcl(reqExcl),
  .reqCache(reqCache), .rspValid(rspValid), .rspId(rspId),
  .rspCode(rspCode), .memWrEn(memWrEn)
);

// File: tb/excl_monitor_bench.sv
`timescale 1ns/1ps
module excl_monitor_bench;

  localparam int NM = 4;
  localparam int AW = 16;
  localparam int TO = 6;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic holdMode = 1'b1;
  logic clrResv = 1'b0;
  logic reqValid = 1'b0;
  logic [IW-1:0] reqId = '0;
  logic [AW-1:0] reqAddr = '0;
  logic reqWrite = 1'b0;
  logic reqExcl = 1'b0;
  logic [1:0] reqCache = 2'b00;
  logic rspValid;
  logic [IW-1:0] rspId;
  logic [1:0] rspCode;
  logic memWrEn;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  excl_monitor #(.NUM_MASTERS(NM), .ADDR_W(AW), .TIMEOUT_CYCLES(TO)) u_excl_monitor (
    .clk(clk), .rstN(rstN), .holdMode(holdMode), .clrResv(clrResv),
    .reqValid(reqValid), .reqId(reqId), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .reqExcl(reqExcl), .reqCache(reqCache), .rspValid(rspValid), .rspId(rspId),
    .rspCode(rspCode), .memWrEn(memWrEn)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive at a falling edge, sample the registered response at the next one
  task automatic xact(input string tag, input int id, input int addr,
                      input bit wr, input bit ex, input int cache,
                      input int expCode, input int expWe);
    reqValid = 1'b1; reqId = IW'(id); reqAddr = AW'(addr);
    reqWrite = wr; reqExcl = ex; reqCache = 2'(cache);
    @(negedge clk);
    clrResv = 1'b0;
    check({tag, " valid"}, int'(rspValid), 1);
    check({tag, " id"}, int'(rspId), id);
    check({tag, " code"}, int'(rspCode), expCode);
    check({tag, " memWrEn"}, int'(memWrEn), expWe);
  endtask

  task automatic idle(input int n);
    reqValid = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      clrResv = 1'b0;
    end
  endtask

  task automatic wipe();
    clrResv = 1'b1;
    idle(1);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset rspValid", int'(rspValid), 0);
    check("R1 reset memWrEn", int'(memWrEn), 0);

    // R1 / R2: plain traffic from every master
    for (int id = 0; id < NM; id++) begin
      xact("R2 plain read", id, 16'h40 + id * 8, 1'b0, 1'b0, 0, 0, 0);
      xact("R2 plain write", id, 16'h80 + id * 8, 1'b1, 1'b0, 0, 0, 1);
    end
    idle(1);
    check("R1 no request no response", int'(rspValid), 0);

    // R3: same-granule sweep over byte offsets
    holdMode = 1'b1;
    for (int off = 0; off < 16; off++) begin
      xact("R3 excl read", 0, 16'h100, 1'b0, 1'b1, 0, 1, 0);
      xact("R3 excl write offset", 0, 16'h100 + off, 1'b1, 1'b1, 0,
           (off < 8) ? 1 : 0, (off < 8) ? 1 : 0);
      wipe();
    end

    // R4: no reservation, then failed write from an outsider
    xact("R4 unreserved write", 2, 16'h200, 1'b1, 1'b1, 0, 0, 0);
    xact("R4 holder read", 0, 16'h200, 1'b0, 1'b1, 0, 1, 0);
    xact("R4 outsider write", 1, 16'h200, 1'b1, 1'b1, 0, 0, 0);
    xact("R4 holder still commits", 0, 16'h200, 1'b1, 1'b1, 0, 1, 1);

    // R5: cancellation by other masters' committed writes
    xact("R5 read", 0, 16'h300, 1'b0, 1'b1, 0, 1, 0);
    xact("R5 write other granule", 1, 16'h308, 1'b1, 1'b0, 0, 0, 1);
    xact("R5 own plain write", 0, 16'h300, 1'b1, 1'b0, 0, 0, 1);
    xact("R5 survives", 0, 16'h300, 1'b1, 1'b1, 0, 1, 1);
    xact("R5 read again", 0, 16'h300, 1'b0, 1'b1, 0, 1, 0);
    xact("R5 intruding write", 3, 16'h304, 1'b1, 1'b0, 0, 0, 1);
    xact("R5 cancelled", 0, 16'h300, 1'b1, 1'b1, 0, 0, 0);
    xact("R5 b reserves", 1, 16'h380, 1'b0, 1'b1, 0, 1, 0);
    xact("R5 a reserves", 0, 16'h3c0, 1'b0, 1'b1, 0, 1, 0);
    xact("R5 b excl commit", 1, 16'h380, 1'b1, 1'b1, 0, 1, 1);
    xact("R5 a unaffected by other granule", 0, 16'h3c0, 1'b1, 1'b1, 0, 1, 1);

    // R6: repeated exclusive write
    xact("R6 read", 2, 16'h400, 1'b0, 1'b1, 0, 1, 0);
    xact("R6 first write", 2, 16'h400, 1'b1, 1'b1, 0, 1, 1);
    xact("R6 repeat write", 2, 16'h400, 1'b1, 1'b1, 0, 0, 0);

    // R7: steal policy
    holdMode = 1'b0;
    xact("R7 a read", 0, 16'h500, 1'b0, 1'b1, 0, 1, 0);
    xact("R7 b steals", 1, 16'h504, 1'b0, 1'b1, 0, 1, 0);
    xact("R7 a write fails", 0, 16'h500, 1'b1, 1'b1, 0, 0, 0);
    xact("R7 b write commits", 1, 16'h500, 1'b1, 1'b1, 0, 1, 1);
    xact("R7 long stall read", 2, 16'h520, 1'b0, 1'b1, 0, 1, 0);
    idle(TO * 3);
    xact("R7 no expiry", 2, 16'h520, 1'b1, 1'b1, 0, 1, 1);

    // R8: hold policy
    holdMode = 1'b1;
    xact("R8 a read", 0, 16'h600, 1'b0, 1'b1, 0, 1, 0);
    xact("R8 b refused", 1, 16'h600, 1'b0, 1'b1, 0, 0, 0);
    xact("R8 a commits", 0, 16'h600, 1'b1, 1'b1, 0, 1, 1);
    xact("R8 b write fails", 1, 16'h600, 1'b1, 1'b1, 0, 0, 0);
    xact("R8 b reads after release", 1, 16'h600, 1'b0, 1'b1, 0, 1, 0);
    xact("R8 b commits", 1, 16'h600, 1'b1, 1'b1, 0, 1, 1);

    // R9: timeout sweep; write sampled d = gap+1 edges after the grant
    for (int gap = 0; gap <= TO + 2; gap++) begin
      xact("R9 read", 3, 16'h700, 1'b0, 1'b1, 0, 1, 0);
      idle(gap);
      xact("R9 write after gap", 3, 16'h700, 1'b1, 1'b1, 0,
           (gap + 1 <= TO) ? 1 : 0, (gap + 1 <= TO) ? 1 : 0);
      wipe();
    end
    xact("R9 holder read", 0, 16'h780, 1'b0, 1'b1, 0, 1, 0);
    idle(TO - 1);
    xact("R9 still held", 1, 16'h780, 1'b0, 1'b1, 0, 0, 0);
    wipe();
    xact("R9 holder read again", 0, 16'h780, 1'b0, 1'b1, 0, 1, 0);
    idle(TO);
    xact("R9 expired hand-off", 1, 16'h780, 1'b0, 1'b1, 0, 1, 0);
    xact("R9 new holder commits", 1, 16'h780, 1'b1, 1'b1, 0, 1, 1);

    // R10: clear input
    xact("R10 read", 2, 16'h800, 1'b0, 1'b1, 0, 1, 0);
    wipe();
    xact("R10 after clear", 2, 16'h800, 1'b1, 1'b1, 0, 0, 0);
    clrResv = 1'b1;
    xact("R10 read with clear", 2, 16'h800, 1'b0, 1'b1, 0, 0, 0);
    xact("R10 no reservation", 2, 16'h800, 1'b1, 1'b1, 0, 0, 0);

    // R11: attribute sweep
    for (int c = 1; c < 4; c++) begin
      xact("R11 dirty read", 1, 16'h900, 1'b0, 1'b1, c, 0, 0);
      xact("R11 no reservation", 1, 16'h900, 1'b1, 1'b1, 0, 0, 0);
      xact("R11 clean read", 1, 16'h900, 1'b0, 1'b1, 0, 1, 0);
      xact("R11 dirty write", 1, 16'h900, 1'b1, 1'b1, c, 0, 0);
      xact("R11 reservation kept", 1, 16'h900, 1'b1, 1'b1, 0, 1, 1);
    end

    idle(2);
    finish();
  end

endmodule